// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host and a 16-bit parallel NOR flash that uses the common unlock-style command set. The host hands over one operation at a time: read, reset, word program, sector erase or chip erase. Each operation comes with a word address and, for a program, a data word. The block turns the operation into the series of bus cycles the flash expects. Each write cycle has a setup clock, a write-enable pulse of programmable width and a hold clock. Program and erase operations then wait for the flash to finish. Completion is seen either on the ready/busy pin or by polling the toggling bit 6 of the data bus. The block then returns one response that carries an error flag and, for a read, the data word.

The request port is valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole of an operation, so the host must hold or withdraw its request until the block is free again. The response is a single-cycle `resp_valid` strobe with no back-pressure. The host must take it in that cycle. `cfg_pulse_clks`, `cfg_poll_mode` and `cfg_timeout` are plain configuration pins and must stay constant while `busy` is high.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `busy` is low, `req_ready` is high, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are high, and `fl_dq_oe` is low.
- R2: Op code 2 (program) issues exactly four writes, as (address, data): (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), then (request address, request data).
- R3: Op code 3 (sector erase) issues exactly six writes: (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), then (request address, 0x30).
- R4: Op code 4 (chip erase) issues the same first five writes as R3, and its sixth write is (0x555,0x10).
- R5: Op code 1 (reset) issues one write of 0xF0 at the request address. Op code 0 (read), and the unused codes 5 to 7, issue one read cycle at the request address with no write, and `resp_data` carries the word read.
- R6: In every write, `fl_we_n` is low for exactly `cfg_pulse_clks` clocks (a value of 0 counts as 1). `fl_ce_n` is low, and `fl_addr` and `fl_dq_out` hold one value, from one clock before the falling edge to one clock after the rising edge. Write and output enable are never low together, and the data bus is never driven while output enable is low.
- R7: `busy` rises the clock after a request is accepted and falls the clock after `resp_valid`. `req_ready` equals the inverse of `busy`. A request presented while busy is ignored and causes no bus cycle.
- R8: With `cfg_poll_mode` low, a program or erase completes once the synchronised ready/busy pin reads high, at least four clocks after the last command write. The response then has `resp_err` low.
- R9: With `cfg_poll_mode` high, a program or erase repeatedly reads the request address. It completes when two consecutive reads return the same bit 6, and the response has `resp_err` low.
- R10: If completion is not seen within `cfg_timeout` clocks of the last command write, the block writes 0xF0 at address 0. The response then has `resp_err` high.
- R11: `resp_valid` is high for exactly one clock per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | Operation code (see R2 to R5) |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Data word to program |
| cfg_pulse_clks | input | 4 | Write/read enable pulse width in clocks |
| cfg_poll_mode | input | 1 | 1 = toggle-bit polling, 0 = ready/busy pin |
| cfg_timeout | input | 20 | Completion time limit in clocks |
| busy | output | 1 | Operation in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_err | output | 1 | Response reports a timeout |
| resp_data | output | 16 | Word returned by a read |
| fl_addr | output | 18 | Flash address bus |
| fl_dq_out | output | 16 | Flash data bus, outgoing value |
| fl_dq_oe | output | 1 | Drive enable for the flash data bus |
| fl_dq_in | input | 16 | Flash data bus, incoming value |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_ryby | input | 1 | Flash ready (high) / busy (low) |

## Verification
`busy` is due one clock after the accepting edge and clears one clock after the `resp_valid` strobe. The bench predicts both from the handshake it observed in the previous sample and compares them on every falling edge. The write-enable pulse width and the setup and hold windows are measured on the same falling-edge samples, on the first sample after each edge of `fl_we_n`. Command writes are captured by the behavioural flash on each rising edge of `fl_we_n`. They are compared in full against the expected sequence once `resp_valid` is seen, because the completion time depends on the flash model. Read data and the error flag are checked in the sample where `resp_valid` is high.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_RESET  = 3'd1,
    OP_PROG   = 3'd2,
    OP_SERASE = 3'd3,
    OP_CERASE = 3'd4
  } nor_op_e;

  typedef enum logic [1:0] {AK_555, AK_2AA, AK_USER, AK_ZERO} addr_kind_e;

  typedef struct packed {
    addr_kind_e akind;
    logic       use_data;
    logic [7:0] code;
  } cmd_step_t;

  function automatic logic [2:0] step_count(logic [2:0] op);
    case (op)
      OP_PROG:             return 3'd4;
      OP_SERASE, OP_CERASE: return 3'd6;
      default:             return 3'd1;
    endcase
  endfunction

  function automatic logic is_write_op(logic [2:0] op);
    return (op == OP_RESET) || (op == OP_PROG) || (op == OP_SERASE) || (op == OP_CERASE);
  endfunction

  function automatic cmd_step_t step_at(logic [2:0] op, logic [2:0] idx);
    cmd_step_t s;
    s = '{akind: AK_555, use_data: 1'b0, code: 8'h00};
    if (op == OP_RESET) begin
      s = '{akind: AK_USER, use_data: 1'b0, code: 8'hF0};
    end else begin
      case (idx)
        3'd0, 3'd3: s = (op == OP_PROG && idx == 3'd3)
                        ? '{akind: AK_USER, use_data: 1'b1, code: 8'h00}
                        : '{akind: AK_555, use_data: 1'b0, code: 8'hAA};
        3'd1, 3'd4: s = '{akind: AK_2AA, use_data: 1'b0, code: 8'h55};
        3'd2:       s = '{akind: AK_555, use_data: 1'b0, code: (op == OP_PROG) ? 8'hA0 : 8'h80};
        default:    s = (op == OP_SERASE)
                        ? '{akind: AK_USER, use_data: 1'b0, code: 8'h30}
                        : '{akind: AK_555, use_data: 1'b0, code: 8'h10};
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] pulse_clks,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);
  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_PULSE, B_HOLD} bst_e;

  bst_e          st;
  logic [PW-1:0] cnt;
  logic [PW-1:0] pulse_last;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic          wr_q;

  assign pulse_last = (pulse_clks == '0) ? '0 : pulse_clks - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= B_IDLE;
      cnt   <= '0;
      a_q   <= '0;
      d_q   <= '0;
      wr_q  <= 1'b0;
      rdata <= '0;
    end else begin
      case (st)
        B_IDLE: if (start) begin
          a_q  <= addr;
          d_q  <= wdata;
          wr_q <= wr;
          st   <= B_SETUP;
        end
        B_SETUP: begin
          cnt <= '0;
          st  <= B_PULSE;
        end
        B_PULSE: begin
          if (cnt >= pulse_last) begin
            st <= B_HOLD;
            if (!wr_q) rdata <= fl_dq_in;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  assign done      = (st == B_HOLD);
  assign fl_addr   = a_q;
  assign fl_dq_out = d_q;
  assign fl_dq_oe  = wr_q && (st != B_IDLE);
  assign fl_ce_n   = (st == B_IDLE);
  assign fl_we_n   = !((st == B_PULSE) && wr_q);
  assign fl_oe_n   = !((st == B_PULSE) && !wr_q);

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> !fl_ce_n); // R6
  AST_NO_OE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_oe_n && !fl_we_n)); // R6
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe); // R6
  AST_ADDR_HELD_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out))); // R6
  AST_HOLD_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (!fl_ce_n && $stable(fl_addr))); // R6
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int PW     = 4,
  parameter int TW     = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [PW-1:0]     cfg_pulse_clks,
  input  logic              cfg_poll_mode,
  input  logic [TW-1:0]     cfg_timeout,
  output logic              busy,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [DATA_W-1:0] resp_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [DATA_W-1:0] fl_dq_in,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  input  logic              fl_ryby
);
  localparam int BLANK = 4;
  localparam int TOG_BIT = 6;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_WAIT, S_POLL, S_RST, S_RESP} sst_e;

  sst_e              st;
  logic [2:0]        op_q;
  logic [2:0]        idx;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [TW-1:0]     tmo_cnt;
  logic              issue_q, have_prev, prev_tog, err_q;
  logic              ryby_m, ryby_s;
  logic              bus_done, bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  cmd_step_t         step;

  always_comb begin
    step      = step_at(op_q, idx);
    bus_wr    = 1'b0;
    bus_addr  = addr_q;
    bus_wdata = '0;
    if (st == S_RST) begin
      bus_wr    = 1'b1;
      bus_addr  = '0;
      bus_wdata = DATA_W'(8'hF0);
    end else if (st == S_CMD && is_write_op(op_q)) begin
      bus_wr    = 1'b1;
      bus_wdata = step.use_data ? data_q : DATA_W'(step.code);
      case (step.akind)
        AK_555:  bus_addr = ADDR_W'(12'h555);
        AK_2AA:  bus_addr = ADDR_W'(12'h2AA);
        AK_ZERO: bus_addr = '0;
        default: bus_addr = addr_q;
      endcase
    end
  end

  nor_bus_cycle #(.AW(ADDR_W), .DW(DATA_W), .PW(PW)) u_bus (
    .clk, .rst_n,
    .start(issue_q), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .pulse_clks(cfg_pulse_clks), .done(bus_done), .rdata(bus_rdata),
    .fl_addr, .fl_dq_out, .fl_dq_oe, .fl_dq_in, .fl_ce_n, .fl_oe_n, .fl_we_n
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ryby_m <= 1'b1;
      ryby_s <= 1'b1;
    end else begin
      ryby_m <= fl_ryby;
      ryby_s <= ryby_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_q      <= '0;
      idx       <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      tmo_cnt   <= '0;
      issue_q   <= 1'b0;
      have_prev <= 1'b0;
      prev_tog  <= 1'b0;
      err_q     <= 1'b0;
      resp_data <= '0;
    end else begin
      issue_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q    <= req_op;
          addr_q  <= req_addr;
          data_q  <= req_wdata;
          idx     <= '0;
          err_q   <= 1'b0;
          issue_q <= 1'b1;
          st      <= S_CMD;
        end
        S_CMD: if (bus_done) begin
          if (idx != step_count(op_q) - 3'd1) begin
            idx     <= idx + 3'd1;
            issue_q <= 1'b1;
          end else if (!is_write_op(op_q)) begin
            resp_data <= bus_rdata;
            st        <= S_RESP;
          end else if (op_q == OP_RESET) begin
            st <= S_RESP;
          end else begin
            tmo_cnt   <= '0;
            have_prev <= 1'b0;
            issue_q   <= cfg_poll_mode;
            st        <= cfg_poll_mode ? S_POLL : S_WAIT;
          end
        end
        S_WAIT: begin
          tmo_cnt <= tmo_cnt + 1'b1;
          if (tmo_cnt >= cfg_timeout) begin
            err_q   <= 1'b1;
            issue_q <= 1'b1;
            st      <= S_RST;
          end else if (ryby_s && tmo_cnt >= TW'(BLANK)) begin
            st <= S_RESP;
          end
        end
        S_POLL: begin
          tmo_cnt <= tmo_cnt + 1'b1;
          if (bus_done) begin
            if (have_prev && prev_tog == bus_rdata[TOG_BIT]) begin
              st <= S_RESP;
            end else if (tmo_cnt >= cfg_timeout) begin
              err_q   <= 1'b1;
              issue_q <= 1'b1;
              st      <= S_RST;
            end else begin
              prev_tog  <= bus_rdata[TOG_BIT];
              have_prev <= 1'b1;
              issue_q   <= 1'b1;
            end
          end
        end
        S_RST: if (bus_done) st <= S_RESP;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign req_ready  = !busy;
  assign resp_valid = (st == S_RESP);
  assign resp_err   = err_q;

  AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R11
  AST_FREE_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !busy); // R7
  AST_BUSY_FROM_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R7
  AST_BUS_QUIET_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> fl_we_n); // R7
  AST_ERR_ONLY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(st) == S_WAIT || $past(st) == S_POLL)); // R10
endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  cfg_pulse_clks = 4'd3;
  logic        cfg_poll_mode = 1'b0;
  logic [19:0] cfg_timeout = 20'd2000;
  logic        busy, resp_valid, resp_err;
  logic [15:0] resp_data;
  logic [17:0] fl_addr;
  logic [15:0] fl_dq_out;
  logic        fl_dq_oe;
  logic [15:0] fl_dq_in;
  logic        fl_ce_n, fl_oe_n, fl_we_n;
  logic        fl_ryby;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  nor_cmd_seq u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr, .req_wdata,
    .cfg_pulse_clks, .cfg_poll_mode, .cfg_timeout, .busy, .resp_valid,
    .resp_err, .resp_data, .fl_addr, .fl_dq_out, .fl_dq_oe, .fl_dq_in,
    .fl_ce_n, .fl_oe_n, .fl_we_n, .fl_ryby
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural flash ----------------
  logic [15:0] mem [int];
  logic [33:0] got_q [$];
  logic [17:0] ha [6];
  logic [15:0] hd [6];
  int          hn = 0;
  int          busy_left = 0;
  bit          stuck = 0;
  logic        tog = 1'b0;

  function automatic int sec_lo(int a);
    if (a < 'h2000) return 0;
    if (a < 'h3000) return 'h2000;
    if (a < 'h4000) return 'h3000;
    if (a < 'h8000) return 'h4000;
    return a & ~'h7FFF;
  endfunction
  function automatic int sec_hi(int a);
    if (a < 'h2000) return 'h2000;
    if (a < 'h3000) return 'h3000;
    if (a < 'h4000) return 'h4000;
    if (a < 'h8000) return 'h8000;
    return (a & ~'h7FFF) + 'h8000;
  endfunction

  always @(posedge fl_we_n) begin
    if (!fl_ce_n) begin
      got_q.push_back({fl_addr, fl_dq_out});
      if (fl_dq_out == 16'h00F0) begin
        hn = 0; busy_left = 0;
      end else begin
        ha[hn] = fl_addr; hd[hn] = fl_dq_out; hn++;
        if (hn == 4 && hd[2] == 16'h00A0) begin
          mem[int'(ha[3])] = (mem.exists(int'(ha[3])) ? mem[int'(ha[3])] : 16'hFFFF) & hd[3];
          busy_left = 30; hn = 0;
        end else if (hn == 6) begin
          if (hd[5] == 16'h0010) mem.delete();
          else begin
            int keys [$];
            foreach (mem[k]) if (k >= sec_lo(int'(ha[5])) && k < sec_hi(int'(ha[5]))) keys.push_back(k);
            foreach (keys[i]) mem.delete(keys[i]);
          end
          busy_left = 60; hn = 0;
        end
      end
    end
  end

  always @(posedge clk) if (busy_left > 0 && !stuck) busy_left--;
  always @(negedge fl_oe_n) if (busy_left > 0) tog = ~tog;
  assign fl_ryby = (busy_left == 0);
  always @(fl_addr or fl_oe_n or busy_left or tog or hn or got_q.size()) begin
    if (busy_left > 0) fl_dq_in = {9'd0, tog, 6'd0};
    else fl_dq_in = mem.exists(int'(fl_addr)) ? mem[int'(fl_addr)] : 16'hFFFF;
  end

  // ---------------- per-clock reference model ----------------
  bit   exp_busy = 0;
  bit   mon_on = 0;
  int   we_run = 0;
  logic p_we = 1, p_ce = 1, p_valid = 0, p_ready = 1, p_resp = 0;
  logic [17:0] p_addr = '0;
  logic [15:0] p_dq = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (p_valid && p_ready) exp_busy = 1;
      else if (p_resp) exp_busy = 0;
      chk(busy == exp_busy, "R7 busy", busy, exp_busy);
      chk(req_ready == !busy, "R7 ready", req_ready, !busy);
      if (p_we && !fl_we_n) begin
        chk(!p_ce && p_addr == fl_addr && p_dq == fl_dq_out, "R6 setup", p_addr, fl_addr);
        we_run = 0;
      end
      if (!fl_we_n) we_run++;
      if (!p_we && fl_we_n) begin
        chk(we_run == ((cfg_pulse_clks == 0) ? 1 : cfg_pulse_clks), "R6 width", we_run, cfg_pulse_clks);
        chk(!fl_ce_n && p_addr == fl_addr && p_dq == fl_dq_out, "R6 hold", fl_addr, p_addr);
      end
    end
    p_we = fl_we_n; p_ce = fl_ce_n; p_addr = fl_addr; p_dq = fl_dq_out;
    p_valid = req_valid; p_ready = req_ready; p_resp = resp_valid;
  end

  // ---------------- stimulus ----------------
  logic [33:0] exp_q [$];
  logic        r_err;
  logic [15:0] r_data;

  task automatic unlock(input logic [7:0] c);
    exp_q.push_back({18'h555, 16'h00AA});
    exp_q.push_back({18'h2AA, 16'h0055});
    exp_q.push_back({18'h555, 8'h00, c});
  endtask

  task automatic issue(input logic [2:0] op, input logic [17:0] a, input logic [15:0] d);
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_resp(input string req);
    int n = 0;
    int pulses = 0;
    while (!resp_valid && n < 20000) begin @(negedge clk); n++; end
    r_err = resp_err; r_data = resp_data;
    chk(resp_valid, {req, " resp"}, resp_valid, 1);
    @(negedge clk);
    pulses = resp_valid;
    chk(pulses == 0, "R11 single strobe", pulses, 0);
  endtask

  task automatic cmp_writes(input string req);
    chk(got_q.size() == exp_q.size(), {req, " count"}, got_q.size(), exp_q.size());
    foreach (exp_q[i])
      if (i < got_q.size()) chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete(); exp_q.delete();
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && req_ready && fl_ce_n && fl_oe_n && fl_we_n && !fl_dq_oe, "R1 reset state",
        {busy, fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 5'b01110);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;

    // R2 program, R8 ready/busy completion, R7 ignored request while busy
    issue(3'd2, 18'h01234, 16'h5A5A);
    repeat (5) @(negedge clk);
    req_op = 3'd4; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    unlock(8'hA0); exp_q.push_back({18'h01234, 16'h5A5A});
    wait_resp("R8 ryby");
    chk(r_err == 0, "R8 no error", r_err, 0);
    cmp_writes("R2 program");

    // R5 read
    issue(3'd0, 18'h01234, 16'h0);
    wait_resp("R5 read");
    chk(r_data == 16'h5A5A, "R5 read data", r_data, 16'h5A5A);
    cmp_writes("R5 read no writes");

    // R5 unused code acts as read
    issue(3'd6, 18'h00001, 16'h0);
    wait_resp("R5 code6");
    chk(r_data == 16'hFFFF, "R5 code6 data", r_data, 16'hFFFF);
    cmp_writes("R5 code6 no writes");

    // R3 sector erase
    issue(3'd3, 18'h01000, 16'h0);
    unlock(8'h80); unlock(8'h00); exp_q.pop_back(); exp_q.push_back({18'h01000, 16'h0030});
    wait_resp("R3 erase");
    cmp_writes("R3 sector erase");
    issue(3'd0, 18'h01234, 16'h0);
    wait_resp("R3 readback");
    chk(r_data == 16'hFFFF, "R3 erased", r_data, 16'hFFFF);
    got_q.delete();

    // R5 reset command
    issue(3'd1, 18'h00777, 16'h0);
    exp_q.push_back({18'h00777, 16'h00F0});
    wait_resp("R5 reset");
    cmp_writes("R5 reset write");

    // R9 polling with a wider pulse (R6)
    cfg_pulse_clks = 4'd5; cfg_poll_mode = 1'b1;
    issue(3'd2, 18'h20000, 16'h1234);
    unlock(8'hA0); exp_q.push_back({18'h20000, 16'h1234});
    wait_resp("R9 poll");
    chk(r_err == 0, "R9 no error", r_err, 0);
    chk(busy_left == 0, "R9 done only when flash idle", busy_left, 0);
    cmp_writes("R9 program");
    issue(3'd0, 18'h20000, 16'h0);
    wait_resp("R9 readback");
    chk(r_data == 16'h1234, "R9 data", r_data, 16'h1234);
    got_q.delete();

    // R4 chip erase in poll mode, pulse width 0 counts as 1
    cfg_pulse_clks = 4'd0;
    issue(3'd4, 18'h3FFFF, 16'h0);
    unlock(8'h80); unlock(8'h10);
    wait_resp("R4 erase");
    cmp_writes("R4 chip erase");
    issue(3'd0, 18'h20000, 16'h0);
    wait_resp("R4 readback");
    chk(r_data == 16'hFFFF, "R4 erased", r_data, 16'hFFFF);
    got_q.delete();

    // R10 timeout in ready/busy mode
    cfg_pulse_clks = 4'd2; cfg_poll_mode = 1'b0; cfg_timeout = 20'd150; stuck = 1;
    issue(3'd2, 18'h00010, 16'h0000);
    unlock(8'hA0); exp_q.push_back({18'h00010, 16'h0000}); exp_q.push_back({18'h00000, 16'h00F0});
    wait_resp("R10 timeout");
    chk(r_err == 1, "R10 error flag", r_err, 1);
    cmp_writes("R10 recovery writes");

    // R10 timeout in poll mode
    cfg_poll_mode = 1'b1;
    issue(3'd2, 18'h00020, 16'h0000);
    stuck = 1;
    unlock(8'hA0); exp_q.push_back({18'h00020, 16'h0000}); exp_q.push_back({18'h00000, 16'h00F0});
    wait_resp("R10 poll timeout");
    chk(r_err == 1, "R10 poll error flag", r_err, 1);
    cmp_writes("R10 poll recovery");
    stuck = 0;

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule